// File: doc/BRIEF.md
# Logic-Embedded Retention Register

This block is a one-bit register that computes a small Boolean function of its data inputs while it stores the result. The stored bit survives loss of supply. Its core is a majority vote over an odd number of inputs. A per-instance function select can also turn the cell into a wide AND or a wide OR. In that case the upper half of the vote inputs is forced to 0 (AND) or to 1 (OR), and only the lower (N_IN+1)/2 data inputs take part in the vote.

The register has two stages. The first is a retained master bit, which is the only state that outlives a power failure. The second is a volatile output stage, which is cleared whenever the power-good input is low. The block steps through three phases. In the store phase, a multi-cycle write places the evaluated function into the master. In standby, the supply is absent. In the sense phase, after power returns, the master is copied into the output stage before the output is marked valid. A write that is cut short by a power failure leaves the master unchanged. A vulnerability flag shows the window in which a failure would lose the value that is being written.

Top module: `nvlr_reg`

## Requirements
- R1: With function select 2'b00 or 2'b11 (majority), the value stored is 1 exactly when at least (N_IN+1)/2 of the N_IN bits of `din` are 1.
- R2: With function select 2'b01 (AND), the value stored is the AND of `din[(N_IN+1)/2-1:0]`. The upper bits of `din` have no effect.
- R3: With function select 2'b10 (OR), the value stored is the OR of `din[(N_IN+1)/2-1:0]`. The upper bits of `din` have no effect.
- R4: After a synchronous reset, `dout`, `dout_vld` and `vuln` are 0, and the retained bit is 0.
- R5: Suppose power-good is first sampled high at edge k after standby. Then `dout_vld` is still 0 after edge k, and after edge k+1 it is 1 with `dout` equal to the retained bit.
- R6: At any edge where power-good is sampled low, `dout`, `dout_vld` and `vuln` become 0, and the retained bit keeps its value.
- R7: Suppose a capture is accepted at edge e. Then the retained bit is written at edge e+WRITE_CYCLES, and `dout` shows the new value with `dout_vld` 1 after edge e+WRITE_CYCLES+1. Between these, `dout_vld` is 0 and `dout` keeps its old value.
- R8: If power-good is low at any edge before the write edge of R7, the write is abandoned, and after the next power-up `dout` shows the previous value.
- R9: `cap_en` is accepted only when power-good is high and `dout_vld` is 1. In standby, sense or store it is ignored.
- R10: `fsel` and `din` are sampled only at the capture edge. Changing them during the write does not change the stored value.
- R11: `vuln` is 1 from the edge after a capture up to and including the write phase, and it falls at the edge where the output stage takes the new value. `vuln` and `dout_vld` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_good | input | 1 | Supply present; low means standby |
| cap_en | input | 1 | Request to evaluate and store |
| fsel | input | 2 | Function select: 00/11 majority, 01 AND, 10 OR |
| din | input | N_IN | Vote inputs |
| dout | output | 1 | Registered output stage |
| dout_vld | output | 1 | Output stage holds the retained value |
| vuln | output | 1 | A write is in flight and not yet visible |

## Verification
The properties assume that power-good and reset are synchronous to the clock and free of glitches between edges, and that `cap_en` is a level input sampled at each edge. The bench drives all inputs on the falling edge only. The bench drops power-good at chosen points: before the write edge, after the write edge, and while `cap_en` is held high through standby and sense. This exercises abandoned writes and ignored requests without making timing assumptions that the assertions do not make.

// File: rtl/nvlr_pkg.sv
package nvlr_pkg;
  localparam logic [1:0] FN_MAJ  = 2'b00;
  localparam logic [1:0] FN_AND  = 2'b01;
  localparam logic [1:0] FN_OR   = 2'b10;
  localparam logic [1:0] FN_MAJX = 2'b11;

  typedef enum logic [1:0] {
    ST_OFF   = 2'b00,
    ST_SENSE = 2'b01,
    ST_READY = 2'b10,
    ST_STORE = 2'b11
  } mode_e;
endpackage

// File: rtl/nvlr_tie_mux.sv
module nvlr_tie_mux
  import nvlr_pkg::*;
#(
  parameter int N_IN = 3
) (
  input  logic [N_IN-1:0] din,
  input  logic [1:0]      fsel,
  output logic [N_IN-1:0] vote
);
  localparam int KEEP = (N_IN + 1) / 2;

  for (genvar i = 0; i < N_IN; i++) begin : g_lane
    if (i < KEEP) begin : g_data
      assign vote[i] = din[i];
    end else begin : g_tied
      assign vote[i] = (fsel == FN_AND) ? 1'b0 :
                       (fsel == FN_OR)  ? 1'b1 : din[i];
    end
  end
endmodule

// File: rtl/nvlr_maj_vote.sv
module nvlr_maj_vote #(
  parameter int N_IN = 3
) (
  input  logic [N_IN-1:0] vote,
  output logic            result
);
  localparam int THRESH = (N_IN + 1) / 2;
  localparam int CNT_W  = $clog2(N_IN + 1);

  logic [CNT_W-1:0] ones;

  always_comb begin
    ones = '0;
    for (int i = 0; i < N_IN; i++) begin
      ones = ones + CNT_W'(vote[i]);
    end
  end

  assign result = (ones >= CNT_W'(THRESH));
endmodule

// File: rtl/nvlr_mode_ctrl.sv
module nvlr_mode_ctrl
  import nvlr_pkg::*;
#(
  parameter int WRITE_CYCLES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pwr_good,
  input  logic cap_en,
  output logic cap_go,
  output logic commit_go,
  output logic sense_go
);
  localparam int CW = (WRITE_CYCLES > 1) ? $clog2(WRITE_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(WRITE_CYCLES - 1);

  mode_e         state;
  logic [CW-1:0] cnt;

  assign cap_go    = pwr_good && (state == ST_READY) && cap_en;
  assign commit_go = pwr_good && (state == ST_STORE) && (cnt == LAST);
  assign sense_go  = pwr_good && (state == ST_SENSE);

  always_ff @(posedge clk) begin
    if (rst || !pwr_good) begin
      state <= ST_OFF;
      cnt   <= '0;
    end else begin
      case (state)
        ST_OFF:   state <= ST_SENSE;
        ST_SENSE: state <= ST_READY;
        ST_READY: begin
          if (cap_en) begin
            state <= ST_STORE;
            cnt   <= '0;
          end
        end
        ST_STORE: begin
          if (cnt == LAST) state <= ST_SENSE;
          else             cnt   <= cnt + 1'b1;
        end
        default:  state <= ST_OFF;
      endcase
    end
  end
endmodule

// File: rtl/nvlr_reg.sv
module nvlr_reg
  import nvlr_pkg::*;
#(
  parameter int N_IN         = 3,
  parameter int WRITE_CYCLES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pwr_good,
  input  logic            cap_en,
  input  logic [1:0]      fsel,
  input  logic [N_IN-1:0] din,
  output logic            dout,
  output logic            dout_vld,
  output logic            vuln
);
  logic [N_IN-1:0] vote;
  logic            eval_bit;
  logic            cap_go, commit_go, sense_go;
  logic            stage_q;
  logic            mst_q;

  nvlr_tie_mux #(.N_IN(N_IN)) u_tie (
    .din  (din),
    .fsel (fsel),
    .vote (vote)
  );

  nvlr_maj_vote #(.N_IN(N_IN)) u_vote (
    .vote   (vote),
    .result (eval_bit)
  );

  nvlr_mode_ctrl #(.WRITE_CYCLES(WRITE_CYCLES)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .pwr_good  (pwr_good),
    .cap_en    (cap_en),
    .cap_go    (cap_go),
    .commit_go (commit_go),
    .sense_go  (sense_go)
  );

  // Volatile staging of the evaluated bit; inputs are frozen here at capture.
  always_ff @(posedge clk) begin
    if (rst)         stage_q <= 1'b0;
    else if (cap_go) stage_q <= eval_bit;
  end

  // Retained master bit: only reset or a completed write changes it.
  always_ff @(posedge clk) begin
    if (rst)            mst_q <= 1'b0;
    else if (commit_go) mst_q <= stage_q;
  end

  // Volatile output stage and flags.
  always_ff @(posedge clk) begin
    if (rst || !pwr_good) begin
      dout     <= 1'b0;
      dout_vld <= 1'b0;
      vuln     <= 1'b0;
    end else begin
      if (sense_go) begin
        dout     <= mst_q;
        dout_vld <= 1'b1;
        vuln     <= 1'b0;
      end else if (cap_go) begin
        dout_vld <= 1'b0;
        vuln     <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/nvlr_chk.sv
module nvlr_chk (
  input logic clk,
  input logic rst,
  input logic pwr_good,
  input logic cap_en,
  input logic dout,
  input logic dout_vld,
  input logic vuln,
  input logic mst
);
  AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (rst)
    !pwr_good |=> (!dout && !dout_vld && !vuln)); // R6

  AST_MST_RETAINED: assert property (@(posedge clk) disable iff (rst)
    !pwr_good |=> $stable(mst)); // R6

  AST_SENSE_DELAY: assert property (@(posedge clk) disable iff (rst)
    $rose(dout_vld) |-> ($past(pwr_good) && $past(pwr_good, 2))); // R5

  AST_CAP_ONLY_VALID: assert property (@(posedge clk) disable iff (rst)
    $rose(vuln) |-> ($past(dout_vld) && $past(cap_en))); // R9

  AST_VULN_EXCL_VLD: assert property (@(posedge clk) disable iff (rst)
    !(vuln && dout_vld)); // R11

  AST_DOUT_HELD: assert property (@(posedge clk) disable iff (rst)
    (dout_vld && $past(dout_vld)) |-> $stable(dout)); // R7
endmodule

bind nvlr_reg nvlr_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .pwr_good (pwr_good),
  .cap_en   (cap_en),
  .dout     (dout),
  .dout_vld (dout_vld),
  .vuln     (vuln),
  .mst      (mst_q)
);

// File: tb/sim_nvlr_reg.sv
`timescale 1ns/1ps
module sim_nvlr_reg;
  localparam int N_IN = 3;
  localparam int WC   = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwr_good = 1'b0;
  logic cap_en = 1'b0;
  logic [1:0] fsel = 2'b00;
  logic [N_IN-1:0] din = '0;
  logic dout, dout_vld, vuln;

  int n_run = 0;
  int n_fail = 0;
  logic prev = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  nvlr_reg #(.N_IN(N_IN), .WRITE_CYCLES(WC)) u0 (
    .clk(clk), .rst(rst), .pwr_good(pwr_good), .cap_en(cap_en),
    .fsel(fsel), .din(din), .dout(dout), .dout_vld(dout_vld), .vuln(vuln)
  );

  // {fsel[1:0], din[2:0], expected}
  localparam logic [5:0] VEC [16] = '{
    {2'b00, 3'b000, 1'b0}, // R1
    {2'b00, 3'b001, 1'b0}, // R1
    {2'b00, 3'b011, 1'b1}, // R1
    {2'b00, 3'b100, 1'b0}, // R1
    {2'b00, 3'b101, 1'b1}, // R1
    {2'b00, 3'b110, 1'b1}, // R1
    {2'b01, 3'b011, 1'b1}, // R2
    {2'b01, 3'b101, 1'b0}, // R2
    {2'b01, 3'b111, 1'b1}, // R2
    {2'b01, 3'b100, 1'b0}, // R2
    {2'b10, 3'b000, 1'b0}, // R3
    {2'b10, 3'b100, 1'b0}, // R3
    {2'b10, 3'b001, 1'b1}, // R3
    {2'b10, 3'b010, 1'b1}, // R3
    {2'b00, 3'b111, 1'b1}, // R1
    {2'b11, 3'b011, 1'b1}  // R1
  };

  task automatic chk(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [1:0] fs, input logic [2:0] d,
                          input logic exp, input string req);
    fsel = fs; din = d; cap_en = 1'b1;
    @(negedge clk);
    cap_en = 1'b0;
    chk("R11 vuln after capture", vuln, 1'b1);
    repeat (WC) @(negedge clk);
    chk("R7 vld low during write", dout_vld, 1'b0);
    chk("R7 dout holds old value", dout, prev);
    @(negedge clk);
    chk("R7 vld back", dout_vld, 1'b1);
    chk("R11 vuln cleared", vuln, 1'b0);
    chk(req, dout, exp);
    prev = exp;
  endtask

  task automatic power_up();
    pwr_good = 1'b1;
    @(negedge clk);
    chk("R5 vld low in sense", dout_vld, 1'b0);
    @(negedge clk);
    chk("R5 vld high", dout_vld, 1'b1);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R4 dout", dout, 1'b0);
    chk("R4 vld", dout_vld, 1'b0);
    chk("R4 vuln", vuln, 1'b0);

    power_up();
    chk("R4 retained bit zero after reset", dout, 1'b0);

    for (int i = 0; i < 16; i++) begin
      do_write(VEC[i][5:4], VEC[i][3:1], VEC[i][0],
               (VEC[i][5:4] == 2'b01) ? "R2 AND" :
               (VEC[i][5:4] == 2'b10) ? "R3 OR" : "R1 majority");
    end

    // R10: change inputs right after capture
    fsel = 2'b01; din = 3'b001; cap_en = 1'b1;
    @(negedge clk);
    cap_en = 1'b0; fsel = 2'b10; din = 3'b111;
    repeat (WC + 1) @(negedge clk);
    chk("R10 inputs frozen at capture", dout, 1'b0);
    prev = 1'b0;

    do_write(2'b00, 3'b111, 1'b1, "R1 majority set");

    // R8: abandon write before the write edge
    fsel = 2'b00; din = 3'b000; cap_en = 1'b1;
    @(negedge clk);
    cap_en = 1'b0;
    chk("R11 vuln in store", vuln, 1'b1);
    pwr_good = 1'b0;
    @(negedge clk);
    chk("R6 dout off", dout, 1'b0);
    chk("R6 vld off", dout_vld, 1'b0);
    chk("R6 vuln off", vuln, 1'b0);
    repeat (4) @(negedge clk);
    cap_en = 1'b1;                 // R9: request held through standby and sense
    @(negedge clk);
    chk("R9 no capture in standby", vuln, 1'b0);
    pwr_good = 1'b1;
    @(negedge clk);
    @(negedge clk);
    cap_en = 1'b0;
    chk("R8 old value kept", dout, 1'b1);
    chk("R5 vld after power-up", dout_vld, 1'b1);
    @(negedge clk);
    chk("R9 request in sense ignored", vuln, 1'b0);
    chk("R9 output unchanged", dout, 1'b1);

    // R7/R6: failure after the write edge keeps the new value
    fsel = 2'b00; din = 3'b000; cap_en = 1'b1;
    @(negedge clk);
    cap_en = 1'b0;
    repeat (WC) @(negedge clk);
    pwr_good = 1'b0;
    repeat (3) @(negedge clk);
    chk("R6 output cleared in standby", dout, 1'b0);
    power_up();
    chk("R7 committed value survives", dout, 1'b0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule